// File: doc/BRIEF.md
# SPI Bit-Rate Prescaler

This block turns the core clock into the timing strobe that a serial-peripheral shifter uses to move its clock line. It pulses `half_tick` for one core cycle at every half-period of the serial clock, so the shifter toggles its clock output (and samples or launches data) on each pulse. The divide ratio comes from an 8-bit rate code. A strap input selects how the code is read.

In the extended reading the ratio is a 4-bit mantissa multiplied by two to the power of a 3-bit exponent. The exponent's bits sit at code positions 4, 6 and 7, and position 5 is not used. In the legacy reading only the low four bits count, and the ratio is twice their value, which gives the even ratios 4 to 30. A run input starts the strobe. The block latches the ratio only when it starts from rest. It stops only at the end of a complete serial-clock period, so the serial clock never gets a shortened half-period.

The controller has three states. `ST_IDLE` is rest. `ST_LEAD` times the first half-period. `ST_TRAIL` times the second half-period. The transitions are:
- START (`ST_IDLE` to `ST_LEAD`, taken when run is high): latches the ratio.
- HALF (`ST_LEAD` to `ST_TRAIL`, taken when the lead count expires).
- WRAP (`ST_TRAIL` to `ST_LEAD`, taken when the trail count expires and run is high).
- STOP (`ST_TRAIL` to `ST_IDLE`, taken when the trail count expires and run is low).

Top module: `spi_rate_prescaler`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `idle` is 1 and `half_tick` is 0.
- R2: With `ext_enc`=1 the divide ratio D is M×2^E, where M=`rate_code[3:0]` and E={`rate_code[7]`,`rate_code[6]`,`rate_code[4]`} with `rate_code[4]` as the least significant bit of E. `rate_code[5]` has no effect.
- R3: With `ext_enc`=1, an M of 0 or 1 behaves as M=2. The smallest ratio is therefore 2.
- R4: With `ext_enc`=0 the ratio is 2×N, where N=`rate_code[3:0]` and an N below 2 counts as 2. `rate_code[7:4]` has no effect, so the ratios are the even values 4 to 30.
- R5: Suppose `run` is sampled high while idle at clock edge k. Then `half_tick` is high for one cycle in the ceil(D/2)-th cycle after edge k. After that it is high for one cycle at alternating spacings of floor(D/2) and ceil(D/2) cycles. The full period is D cycles.
- R6: When D is even, the two half-periods are equal (D/2 cycles each).
- R7: Changes to `rate_code` or `ext_enc` while not idle do not change the tick spacing. The new value applies from the next start out of idle.
- R8: When `run` is low, the block stops only after the second tick of a period. `idle` rises on the cycle after that tick, and never in the middle of a period.
- R9: `idle` is 0 exactly while a period is in progress. `half_tick` is never 1 while `idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code | input | 8 | Divide-ratio code |
| ext_enc | input | 1 | Code reading: 1 mantissa/exponent, 0 legacy even ratio |
| run | input | 1 | Start and keep the serial clock running |
| half_tick | output | 1 | One-cycle strobe at each serial-clock half-period |
| idle | output | 1 | High while no period is in progress |

## Verification
The assertions assume that `run`, `rate_code` and `ext_enc` are synchronous to `clk` and change only between edges. They also assume that reset is held for at least one clock edge. The bench changes every input on the falling edge. It holds reset across several edges before release. It changes the rate code in the middle of a period only on purpose, to check that the latched ratio is kept. The half-period checks in the checker use the latched ratio and not the live inputs, so those mid-period changes stay within what the assertions take for granted.

// File: rtl/spi_psc_pkg.sv
package spi_psc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } psc_state_e;
endpackage

// File: rtl/spi_psc_decode.sv
module spi_psc_decode #(
    parameter int MANT_W = 4,
    parameter int EXP_W  = 3,
    localparam int FIELD_W = MANT_W + 1 + EXP_W,
    localparam int DIV_W   = MANT_W + (1 << EXP_W) - 1
) (
    input  logic [FIELD_W-1:0] rate_code,
    input  logic               ext_enc,
    output logic [DIV_W-1:0]   div_out
);
    logic [EXP_W-1:0]  exp_v;
    logic [MANT_W-1:0] mant_raw;
    logic [MANT_W-1:0] mant_eff;
    logic [DIV_W-1:0]  div_ext;
    logic [DIV_W-1:0]  div_leg;
    logic              gap_unused;

    // Exponent bit 0 sits just above the mantissa; the rest skip one spare bit.
    for (genvar i = 0; i < EXP_W; i++) begin : g_exp
        if (i == 0) begin : g_lo
            assign exp_v[i] = rate_code[MANT_W];
        end else begin : g_hi
            assign exp_v[i] = rate_code[MANT_W + 1 + i];
        end
    end

    assign gap_unused = rate_code[MANT_W + 1];
    assign mant_raw   = rate_code[MANT_W-1:0];
    assign mant_eff   = (mant_raw < MANT_W'(2)) ? MANT_W'(2) : mant_raw;

    always_comb begin
        div_ext = DIV_W'(mant_eff) << exp_v;
        div_leg = DIV_W'(mant_eff) << 1;
        div_out = ext_enc ? div_ext : div_leg;
    end
endmodule

// File: rtl/spi_psc_halves.sv
module spi_psc_halves #(
    parameter int DIV_W = 11
) (
    input  logic [DIV_W-1:0] div_in,
    output logic [DIV_W-1:0] lead_m1,
    output logic [DIV_W-1:0] trail_m1
);
    logic [DIV_W:0] sum_up;

    always_comb begin
        sum_up   = {1'b0, div_in} + (DIV_W+1)'(1);
        lead_m1  = DIV_W'(sum_up >> 1) - DIV_W'(1);
        trail_m1 = (div_in >> 1) - DIV_W'(1);
    end
endmodule

// File: rtl/spi_psc_timer.sv
module spi_psc_timer
    import spi_psc_pkg::*;
#(
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic [DIV_W-1:0] div_hold,
    output logic             half_tick,
    output logic             idle
);
    psc_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] div_q, div_d;
    logic [DIV_W-1:0] div_sel;
    logic [DIV_W-1:0] lead_m1, trail_m1;
    logic             expired;

    assign div_sel = (state_q == ST_IDLE) ? div_in : div_q;
    assign expired = (cnt_q == '0);

    spi_psc_halves #(.DIV_W(DIV_W)) u_halves (
        .div_in  (div_sel),
        .lead_m1 (lead_m1),
        .trail_m1(trail_m1)
    );

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        div_d   = div_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    div_d   = div_in;
                    cnt_d   = lead_m1;
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (expired) begin
                    cnt_d   = trail_m1;
                    state_d = ST_TRAIL;
                end else begin
                    cnt_d = cnt_q - DIV_W'(1);
                end
            end
            ST_TRAIL: begin
                if (expired) begin
                    if (run) begin
                        cnt_d   = lead_m1;
                        state_d = ST_LEAD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - DIV_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            div_q   <= DIV_W'(2);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            div_q   <= div_d;
        end
    end

    always_comb begin
        idle      = (state_q == ST_IDLE);
        half_tick = (state_q != ST_IDLE) && expired;
        div_hold  = div_q;
    end
endmodule

// File: rtl/spi_rate_prescaler.sv
module spi_rate_prescaler #(
    parameter int MANT_W = 4,
    parameter int EXP_W  = 3,
    localparam int FIELD_W = MANT_W + 1 + EXP_W,
    localparam int DIV_W   = MANT_W + (1 << EXP_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] rate_code,
    input  logic               ext_enc,
    input  logic               run,
    output logic               half_tick,
    output logic               idle
);
    logic [DIV_W-1:0] div_dec;
    logic [DIV_W-1:0] div_hold;

    spi_psc_decode #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_dec (
        .rate_code(rate_code),
        .ext_enc  (ext_enc),
        .div_out  (div_dec)
    );

    spi_psc_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_in   (div_dec),
        .div_hold (div_hold),
        .half_tick(half_tick),
        .idle     (idle)
    );
endmodule

// File: rtl/spi_rate_prescaler_chk.sv
module spi_rate_prescaler_chk #(
    parameter int DIV_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_enc,
    input logic             half_tick,
    input logic             idle,
    input logic [DIV_W-1:0] div_dec,
    input logic [DIV_W-1:0] div_hold
);
    logic [DIV_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap <= DIV_W'(1);
        else if (idle || half_tick) gap <= DIV_W'(1);
        else                       gap <= gap + DIV_W'(1);
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (idle && !half_tick));

    assert_ext_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_enc |-> (div_dec >= DIV_W'(2)));

    assert_legacy_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_enc |-> (!div_dec[0] && div_dec >= DIV_W'(4) && div_dec <= DIV_W'(30)));

    assert_even_halves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && !div_hold[0]) |-> (gap == (div_hold >> 1)));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle)) |-> $stable(div_hold));

    assert_no_mid_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !half_tick) |=> !idle);

    assert_stop_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(half_tick));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !half_tick);
endmodule

bind spi_rate_prescaler spi_rate_prescaler_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_enc  (ext_enc),
    .half_tick(half_tick),
    .idle     (idle),
    .div_dec  (div_dec),
    .div_hold (div_hold)
);

// File: tb/sim_spi_rate_prescaler.sv
`timescale 1ns/1ps
module sim_spi_rate_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rate_code = 8'h00;
    logic       ext_enc = 1'b0;
    logic       run = 1'b0;
    logic       half_tick;
    logic       idle;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    bit    cmp_on = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_act = 0;
    int m_pos = 0;
    int m_div = 2;

    always #5 clk = ~clk;

    spi_rate_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .ext_enc(ext_enc),
        .run(run), .half_tick(half_tick), .idle(idle)
    );

    function automatic int exp_div(input logic [7:0] f, input logic m);
        int lo, e;
        lo = f % 16;
        if (lo < 2) lo = 2;
        if (m) begin
            e = ((f >> 4) & 1) + 2 * ((f >> 6) & 3);
            return lo * (1 << e);
        end
        return 2 * lo;
    endfunction

    task automatic chk(input string tag, input int got, input int expv);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0; m_pos = 0; m_div = 2;
        end else if (!m_act) begin
            if (run) begin m_act = 1; m_pos = 0; m_div = exp_div(rate_code, ext_enc); end
        end else if (m_pos == m_div - 1) begin
            if (run) m_pos = 0; else m_act = 0;
        end else begin
            m_pos++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk({cur_req, " tick"}, int'(half_tick),
                int'(m_act && (m_pos == (m_div + 1) / 2 - 1 || m_pos == m_div - 1)));
            chk({cur_req, " idle R9"}, int'(idle), int'(!m_act));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_fail++;
            $display("FAIL watchdog R9 got %0d expected below 190000", cyc);
            summary();
        end
    end

    // run for nticks ticks, checking every gap, then stop and wait for idle
    task automatic run_periods(input logic [7:0] f, input logic m, input int nticks, input string tag);
        int d, h1, h2, c, seen, last, n;
        d = exp_div(f, m); h1 = (d + 1) / 2; h2 = d / 2;
        @(negedge clk);
        cur_req = tag; rate_code = f; ext_enc = m; run = 1'b1;
        c = 0; seen = 0; last = 0;
        while (seen < nticks && c < 5000) begin
            @(negedge clk); c++;
            if (half_tick) begin
                seen++;
                chk({tag, " R5 gap"}, c - last, (seen % 2 == 1) ? h1 : h2);
                last = c;
            end
        end
        run = 1'b0; n = 0;
        while (!idle && n < 5000) begin @(negedge clk); n++; end
        chk({tag, " R8 idle after stop"}, int'(idle), 1);
    endtask

    initial begin
        int c, t;
        repeat (3) @(negedge clk);
        chk("R1 idle in reset", int'(idle), 1);
        chk("R1 tick in reset", int'(half_tick), 0);
        rst_n = 1'b1; cmp_on = 1;
        @(negedge clk);
        chk("R1 idle after release", int'(idle), 1);
        chk("R1 tick after release", int'(half_tick), 0);

        // legacy reading, every low nibble, junk in the upper bits on some
        for (int n = 0; n < 16; n++)
            run_periods(8'((n % 3 == 0) ? (8'hE0 | n) : (8'h10 | n)), 1'b0, 4, "R4");

        // extended reading sweep, bit 5 toggled on odd mantissas
        for (int mn = 0; mn < 16; mn += 3)
            for (int e = 0; e < 8; e++)
                run_periods(8'(mn | ((e & 1) << 4) | ((e >> 1) << 6) | ((mn % 2) << 5)),
                            1'b1, 2, "R2");
        run_periods(8'h00, 1'b1, 6, "R3");
        run_periods(8'h01, 1'b1, 6, "R3");
        run_periods(8'h21, 1'b1, 4, "R3");
        run_periods(8'h03, 1'b1, 6, "R5");
        run_periods(8'h0A, 1'b1, 4, "R6");
        run_periods(8'hDF, 1'b1, 2, "R2");

        // R7: ratio 6 running, code changed mid-period to ratio 15
        @(negedge clk);
        cur_req = "R7"; rate_code = 8'h13; ext_enc = 1'b0; run = 1'b1;
        repeat (2) @(negedge clk);
        rate_code = 8'h0F; ext_enc = 1'b1;
        c = 0; t = 0;
        while (t < 4 && c < 200) begin @(negedge clk); c++; if (half_tick) t++; end
        chk("R7 fourth tick after change", c, 10);
        run = 1'b0;
        while (!idle) @(negedge clk);
        run = 1'b1; c = 0;
        while (!half_tick && c < 200) begin @(negedge clk); c++; end
        chk("R7 new ratio after restart", c, 8);
        run = 1'b0;
        while (!idle) @(negedge clk);

        // R8: run dropped one cycle into a ratio-10 period
        cur_req = "R8"; rate_code = 8'h0A; ext_enc = 1'b1; run = 1'b1;
        @(negedge clk);
        run = 1'b0; c = 0; t = 0;
        while (!idle && c < 200) begin
            if (half_tick) t++;
            @(negedge clk); c++;
        end
        chk("R8 ticks before stop", t, 2);
        chk("R8 cycles before idle", c, 10);

        repeat (4) @(negedge clk);
        chk("R9 quiet idle tick", int'(half_tick), 0);
        summary();
    end
endmodule